// File: doc/BRIEF.md
# Raster Timing and Vertical Event Generator

This block walks a display raster one pixel per clock and reports where it is. A horizontal counter runs across each line. A line counter steps at the start of horizontal sync, so every vertical event lands on the sync edge of its line. From these two counters the block derives level flags and single-clock event pulses:

- Level flags: horizontal active, horizontal sync, vertical blank, vertical sync and display enable.
- Event pulses: start of vertical blank, start of vertical sync and frame start.

Frame start is placed at the start of horizontal blank. It comes one to four raster lines after vertical blank begins, chosen by a two-bit delay field.

The timing values enter through pending inputs. The block keeps a private active copy of them. That copy is reloaded only on a load strobe, which fires together with the start-of-vertical-blank pulse. Software can therefore change the pending values at any time, and the raster changes only at a frame boundary. While reset is held, the active copy follows the pending inputs.

The configuration must satisfy all of these:

- 1 <= hblank_start < hsync_start < htotal
- 1 <= vblank_start <= vsync_start < vsync_end <= vtotal
- the frame-start delay is less than vtotal

A blanking interval of only three lines is legal.

Top module: `raster_event_gen`

## Requirements
- R1: `h_pos` counts 0 to htotal-1 and then returns to 0. `v_pos` steps by one in the same cycle that `h_pos` reaches hsync_start. It returns to 0 after vtotal-1.
- R2: `h_active` is 1 when h_pos < hblank_start. `h_sync` is 1 when h_pos >= hsync_start, through the end of the line.
- R3: `v_blank` is 1 when v_pos >= vblank_start. `v_sync` is 1 when vsync_start <= v_pos < vsync_end. `disp_en` equals h_active AND NOT v_blank.
- R4: `vblank_evt` is a one-cycle pulse. It is high exactly when h_pos = hsync_start and v_pos = vblank_start.
- R5: `vsync_evt` is a one-cycle pulse. It is high exactly when h_pos = hsync_start and v_pos = vsync_start.
- R6: `frame_evt` is a one-cycle pulse. It is high exactly when h_pos = hblank_start and v_pos = (vblank_start + delay) mod vtotal, where delay is the two-bit `pend_fs_delay` value (0 to 3). This places it 1 to 4 lines after vertical blank begins.
- R7: `cfg_load` pulses in the same cycle as `vblank_evt`. Pending values govern the raster from the next pixel on. Before that pulse, changed pending values have no effect on any output.
- R8: While `rst` is high, every output is 0 and the active copy follows the pending inputs. The first cycle after release reports position (0,0).
- R9: A mode with vsync_start = vblank_start+1, vsync_end = vblank_start+2 and vtotal = vblank_start+3 produces exactly one of each event per frame. This holds with every delay value, including one that wraps frame start to line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_htotal | input | 12 | Pending pixels per line |
| pend_hblank_start | input | 12 | Pending first horizontal blank pixel |
| pend_hsync_start | input | 12 | Pending first horizontal sync pixel |
| pend_vtotal | input | 12 | Pending lines per frame |
| pend_vblank_start | input | 12 | Pending first vertical blank line |
| pend_vsync_start | input | 12 | Pending first vertical sync line |
| pend_vsync_end | input | 12 | Pending first line after vertical sync |
| pend_fs_delay | input | 2 | Pending extra frame-start lines (0 to 3) |
| h_pos | output | 12 | Reported pixel position |
| v_pos | output | 12 | Reported line (sync-aligned) |
| h_active | output | 1 | Horizontal active |
| h_sync | output | 1 | Horizontal sync |
| v_blank | output | 1 | Vertical blank |
| v_sync | output | 1 | Vertical sync |
| disp_en | output | 1 | Visible pixel |
| vblank_evt | output | 1 | Start-of-vertical-blank pulse |
| vsync_evt | output | 1 | Start-of-vertical-sync pulse |
| frame_evt | output | 1 | Frame-start pulse |
| cfg_load | output | 1 | Active-copy reload strobe |

## Verification
Every output goes through one register stage. In each cycle the flags and pulses therefore describe the same raster position that `h_pos`/`v_pos` report, and the first position appears one clock after reset is released. The bench keeps its own position and active-configuration model and samples at the falling edge after each rising edge. It checks all outputs of that cycle against the modelled position. The model swaps in the pending values only after the cycle that shows the load position, which matches the rule that the new values govern from the next pixel.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int HW = 12;
  localparam int VW = 12;
  localparam int DW = 2;

  typedef struct packed {
    logic [HW-1:0] htotal;
    logic [HW-1:0] hblank;
    logic [HW-1:0] hsync;
    logic [VW-1:0] vtotal;
    logic [VW-1:0] vblank;
    logic [VW-1:0] vsync_s;
    logic [VW-1:0] vsync_e;
    logic [DW-1:0] fs_dly;
  } tcfg_t;
endpackage

// File: rtl/tg_cfg_bank.sv
module tg_cfg_bank
  import tg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  tcfg_t pend,
  output tcfg_t cur
);
  always_ff @(posedge clk) begin
    if (rst || load) cur <= pend;
  end

  // R7: a load copies the pending set
  a_r7_load_copies: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur == $past(pend)));
  // R7: without a load the active set holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur));
endmodule

// File: rtl/tg_raster_cnt.sv
module tg_raster_cnt
  import tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tcfg_t         cfg,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt
);
  logic [HW-1:0] hnext;

  always_comb begin
    if (hcnt >= cfg.htotal - 1'b1) hnext = '0;
    else                           hnext = hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hnext;
      if (hnext == cfg.hsync) begin
        if (vcnt >= cfg.vtotal - 1'b1) vcnt <= '0;
        else                           vcnt <= vcnt + 1'b1;
      end
    end
  end

  // R1: last pixel of a line is followed by pixel 0
  a_r1_hwrap: assert property (@(posedge clk) disable iff (rst)
    (hcnt == cfg.htotal - 1'b1) |=> (hcnt == '0));
  // R1: the line counter only moves onto the sync pixel
  a_r1_vstep: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (vcnt != $past(vcnt))) |-> (hcnt == cfg.hsync));
endmodule

// File: rtl/tg_event_dec.sv
module tg_event_dec
  import tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  tcfg_t         cfg,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  output logic          load_c,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          h_active,
  output logic          h_sync,
  output logic          v_blank,
  output logic          v_sync,
  output logic          disp_en,
  output logic          vblank_evt,
  output logic          vsync_evt,
  output logic          frame_evt,
  output logic          cfg_load
);
  logic [VW:0]   fs_sum;
  logic [VW-1:0] fs_line;
  logic          ha_c, vb_c, at_sync;

  always_comb begin
    fs_sum = {1'b0, cfg.vblank} + {{(VW+1-DW){1'b0}}, cfg.fs_dly};
    if (fs_sum >= {1'b0, cfg.vtotal}) fs_line = VW'(fs_sum - {1'b0, cfg.vtotal});
    else                              fs_line = fs_sum[VW-1:0];
    ha_c    = (hcnt < cfg.hblank);
    vb_c    = (vcnt >= cfg.vblank);
    at_sync = (hcnt == cfg.hsync);
    load_c  = at_sync && (vcnt == cfg.vblank);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos <= '0; v_pos <= '0;
      h_active <= 1'b0; h_sync <= 1'b0; v_blank <= 1'b0; v_sync <= 1'b0;
      disp_en <= 1'b0; vblank_evt <= 1'b0; vsync_evt <= 1'b0;
      frame_evt <= 1'b0; cfg_load <= 1'b0;
    end else begin
      h_pos      <= hcnt;
      v_pos      <= vcnt;
      h_active   <= ha_c;
      h_sync     <= (hcnt >= cfg.hsync);
      v_blank    <= vb_c;
      v_sync     <= (vcnt >= cfg.vsync_s) && (vcnt < cfg.vsync_e);
      disp_en    <= ha_c && !vb_c;
      vblank_evt <= load_c;
      vsync_evt  <= at_sync && (vcnt == cfg.vsync_s);
      frame_evt  <= (hcnt == cfg.hblank) && (vcnt == fs_line);
      cfg_load   <= load_c;
    end
  end

  // R4: start-of-blank pulse lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    vblank_evt |=> !vblank_evt);
  // R6: frame start lasts one cycle and sits in horizontal blank
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> !frame_evt);
  a_r6_in_hblank: assert property (@(posedge clk) disable iff (rst)
    frame_evt |-> (!h_active && !h_sync));
  // R5: vsync start is seen on a sync pixel
  a_r5_on_sync: assert property (@(posedge clk) disable iff (rst)
    vsync_evt |-> h_sync);
  // R3: vertical sync lies within vertical blank
  a_r3_vs_in_vb: assert property (@(posedge clk) disable iff (rst)
    v_sync |-> v_blank);
endmodule

// File: rtl/raster_event_gen.sv
module raster_event_gen
  import tg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] pend_htotal,
  input  logic [HW-1:0] pend_hblank_start,
  input  logic [HW-1:0] pend_hsync_start,
  input  logic [VW-1:0] pend_vtotal,
  input  logic [VW-1:0] pend_vblank_start,
  input  logic [VW-1:0] pend_vsync_start,
  input  logic [VW-1:0] pend_vsync_end,
  input  logic [DW-1:0] pend_fs_delay,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          h_active,
  output logic          h_sync,
  output logic          v_blank,
  output logic          v_sync,
  output logic          disp_en,
  output logic          vblank_evt,
  output logic          vsync_evt,
  output logic          frame_evt,
  output logic          cfg_load
);
  tcfg_t         pend, cur;
  logic          load_c;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  always_comb begin
    pend.htotal  = pend_htotal;
    pend.hblank  = pend_hblank_start;
    pend.hsync   = pend_hsync_start;
    pend.vtotal  = pend_vtotal;
    pend.vblank  = pend_vblank_start;
    pend.vsync_s = pend_vsync_start;
    pend.vsync_e = pend_vsync_end;
    pend.fs_dly  = pend_fs_delay;
  end

  tg_cfg_bank u_bank (.clk(clk), .rst(rst), .load(load_c), .pend(pend), .cur(cur));

  tg_raster_cnt u_cnt (.clk(clk), .rst(rst), .cfg(cur), .hcnt(hcnt), .vcnt(vcnt));

  tg_event_dec u_dec (
    .clk(clk), .rst(rst), .cfg(cur), .hcnt(hcnt), .vcnt(vcnt), .load_c(load_c),
    .h_pos(h_pos), .v_pos(v_pos), .h_active(h_active), .h_sync(h_sync),
    .v_blank(v_blank), .v_sync(v_sync), .disp_en(disp_en),
    .vblank_evt(vblank_evt), .vsync_evt(vsync_evt), .frame_evt(frame_evt),
    .cfg_load(cfg_load)
  );
endmodule

// File: tb/tb_raster_event_gen.sv
module tb_raster_event_gen;
  import tg_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [HW-1:0] p_ht, p_hb, p_hs;
  logic [VW-1:0] p_vt, p_vb, p_vss, p_vse;
  logic [DW-1:0] p_d;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic h_active, h_sync, v_blank, v_sync, disp_en;
  logic vblank_evt, vsync_evt, frame_evt, cfg_load;

  raster_event_gen dut (
    .clk(clk), .rst(rst),
    .pend_htotal(p_ht), .pend_hblank_start(p_hb), .pend_hsync_start(p_hs),
    .pend_vtotal(p_vt), .pend_vblank_start(p_vb), .pend_vsync_start(p_vss),
    .pend_vsync_end(p_vse), .pend_fs_delay(p_d),
    .h_pos(h_pos), .v_pos(v_pos), .h_active(h_active), .h_sync(h_sync),
    .v_blank(v_blank), .v_sync(v_sync), .disp_en(disp_en),
    .vblank_evt(vblank_evt), .vsync_evt(vsync_evt), .frame_evt(frame_evt),
    .cfg_load(cfg_load)
  );

  // columns: htotal, hblank, hsync, vtotal, vblank, vsync_s, vsync_e, delay, cycles
  localparam int NE = 4;
  localparam int T [NE][9] = '{
    '{12, 7, 9, 9, 5, 6, 8, 1, 400},
    '{ 8, 3, 5, 6, 3, 4, 5, 2, 400},
    '{10, 6, 8, 6, 3, 4, 5, 0, 300},   // R9 short blanking
    '{10, 6, 8, 6, 3, 4, 5, 3, 300}    // R9 delay wraps frame start to line 0
  };

  int total = 0, bad = 0;
  int mh, mv;
  int c_ht, c_hb, c_hs, c_vt, c_vb, c_vss, c_vse, c_d;
  int n_sov, n_svs, n_fs;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d,%0d)", req, act, exp, mh, mv);
    end
  endtask

  task automatic load_model();
    c_ht = p_ht; c_hb = p_hb; c_hs = p_hs; c_vt = p_vt;
    c_vb = p_vb; c_vss = p_vss; c_vse = p_vse; c_d = p_d;
  endtask

  task automatic set_pend(input int i);
    p_ht = HW'(T[i][0]); p_hb = HW'(T[i][1]); p_hs = HW'(T[i][2]);
    p_vt = VW'(T[i][3]); p_vb = VW'(T[i][4]); p_vss = VW'(T[i][5]);
    p_vse = VW'(T[i][6]); p_d = DW'(T[i][7]);
  endtask

  task automatic compare();
    int fsl;
    bit at_s;
    fsl  = (c_vb + c_d) % c_vt;
    at_s = (mh == c_hs);
    chk("R1 h_pos", int'(h_pos), mh);
    chk("R1 v_pos", int'(v_pos), mv);
    chk("R2 h_active", int'(h_active), int'(mh < c_hb));
    chk("R2 h_sync", int'(h_sync), int'(mh >= c_hs));
    chk("R3 v_blank", int'(v_blank), int'(mv >= c_vb));
    chk("R3 v_sync", int'(v_sync), int'(mv >= c_vss && mv < c_vse));
    chk("R3 disp_en", int'(disp_en), int'(mh < c_hb && mv < c_vb));
    chk("R4 vblank_evt", int'(vblank_evt), int'(at_s && mv == c_vb));
    chk("R5 vsync_evt", int'(vsync_evt), int'(at_s && mv == c_vss));
    chk("R6 frame_evt", int'(frame_evt), int'(mh == c_hb && mv == fsl));
    chk("R7 cfg_load", int'(cfg_load), int'(at_s && mv == c_vb));
    n_sov += int'(vblank_evt);
    n_svs += int'(vsync_evt);
    n_fs  += int'(frame_evt);
  endtask

  task automatic advance();
    int hn;
    bit latch;
    latch = (mh == c_hs) && (mv == c_vb);
    hn = (mh >= c_ht - 1) ? 0 : mh + 1;
    if (hn == c_hs) mv = (mv >= c_vt - 1) ? 0 : mv + 1;
    mh = hn;
    if (latch) load_model();
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    advance();
  endtask

  task automatic reset_check(input string tag);
    chk({tag, " h_pos"}, int'(h_pos), 0);
    chk({tag, " v_pos"}, int'(v_pos), 0);
    chk({tag, " flags"}, int'({h_active, h_sync, v_blank, v_sync, disp_en}), 0);
    chk({tag, " events"}, int'({vblank_evt, vsync_evt, frame_evt, cfg_load}), 0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    set_pend(0);
    load_model();
    repeat (3) @(negedge clk);
    reset_check("R8 reset");
    rst = 1'b0;
    mh = 0; mv = 0;
    n_sov = 0; n_svs = 0; n_fs = 0;

    // table walk: each entry is taken in at the next vblank load (R7)
    for (int i = 0; i < NE; i++) begin
      set_pend(i);
      for (int n = 0; n < T[i][8]; n++) step();
    end

    // R9: one full frame of the short mode yields one of each event
    while (!(mh == 0 && mv == 0)) step();
    n_sov = 0; n_svs = 0; n_fs = 0;
    for (int n = 0; n < c_ht * c_vt; n++) step();
    chk("R9 vblank_evt count", n_sov, 1);
    chk("R9 vsync_evt count", n_svs, 1);
    chk("R9 frame_evt count", n_fs, 1);

    // R7: pending change mid-frame, old values hold until the load
    while (!(mh == 0 && mv == 0)) step();
    set_pend(0);
    for (int n = 0; n < 3; n++) step();
    chk("R7 no early effect (htotal old)", c_ht, T[3][0]);
    for (int n = 0; n < 500; n++) step();
    chk("R7 new htotal taken", c_ht, T[0][0]);

    // R8: reset mid-frame
    @(negedge clk);
    rst = 1'b1;
    set_pend(1);
    @(posedge clk);
    @(negedge clk);
    reset_check("R8 mid reset");
    load_model();
    rst = 1'b0;
    mh = 0; mv = 0;
    step();
    for (int n = 0; n < 200; n++) step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule